// File: doc/BRIEF.md
# Microcoded ALU and Shifter Datapath

This block is the execution half of a microcoded machine. Each clock cycle it takes one 15-bit command word. The word is split into four slices, one for each unit. Each slice holds a short code for that unit, so the word as a whole is horizontal while each slice is vertical. The source slice puts a value on the source bus. That value comes from one of eight general registers, from the data input, or from the 12-bit constant that comes with the microinstruction. The ALU slice combines the source bus with the accumulator. The shifter slice reshapes the ALU result. The destination slice writes the shifter output into a register, into the accumulator, or nowhere.

The shifter output and the carry and zero flags are combinational outputs of the current command. An external sequencer can therefore branch on the flags in the same cycle as the command that produced them. The write happens on the next rising clock edge. The command and data pins are plain level inputs with no handshake. The block accepts a new command every cycle and never applies back-pressure, so whatever drives it must present a valid word on every cycle.

Top module: `ucdp_core`

## Requirements
- R1: Source code (cmd[14:11]) 0–7 puts register Rn on the source bus. Code 8 selects din_i. Code 9 selects const_i, zero-extended to 16 bits.
- R2: ALU code (cmd[10:7]) gives the arithmetic results modulo 2^16: 0 = ACC, 1 = S, 2 = ACC+S, 3 = ACC−S, 4 = S−ACC, 8 = ACC+1, 9 = S−1.
- R3: ALU code 5 gives ACC AND S, 6 gives ACC OR S, 7 gives NOT S, 10 gives constant 0 and 11 gives constant 1. Codes 12–15 give 0.
- R4: Shifter code (cmd[6:4]) gives: 0 = logical left, 1 = logical right, 2 = rotate left, 3 = rotate right, 4 = arithmetic left (zero fill), 5 = arithmetic right (sign fill). Each moves the value by one bit.
- R5: cf_o takes the bit shifted out of the word. For codes 0, 2 and 4 this is the MSB of the ALU result. For codes 1, 3 and 5 it is the LSB.
- R6: zf_o is 1 exactly when result_o is all zeros.
- R7: Shifter codes 7 and 6 pass the ALU result unchanged and force cf_o to 0.
- R8: Destination code (cmd[3:0]) 0–7 writes result_o into Rn on the next rising clock edge.
- R9: Destination code 8 writes result_o into the accumulator (acc_o). The accumulator is always the other ALU operand.
- R10: Destination code 15, and codes 9–14, change neither the accumulator nor any register.
- R11: While rst_n is low, the accumulator and R0–R7 are cleared to 0.
- R12: result_o, cf_o and zf_o reflect the present command in the same cycle, and each command completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 15 | Command word: source, ALU, shifter and destination slices |
| const_i | input | 12 | Address/constant field of the microinstruction |
| din_i | input | 16 | External data input |
| result_o | output | 16 | Shifter output of the current command |
| acc_o | output | 16 | Accumulator contents |
| cf_o | output | 1 | Carry flag from the shifter |
| zf_o | output | 1 | Zero flag of result_o |

## Verification
The hardest case is showing that a write to a reserved destination code left all eight registers untouched. The register file has no port of its own, so it cannot be seen directly. The stimulus first loads every register with a distinct value. It then issues the reserved-code write with a value that matches none of them. Finally it reads R0 through R7 back through the source bus in pass mode, one per cycle. Shifter-generated zero flags are reached by feeding the input port a word whose only set bit is the MSB, then shifting it left.

// File: rtl/ucdp_pkg.sv
package ucdp_pkg;
  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);

  localparam logic [3:0] SRC_DIN   = 4'h8;
  localparam logic [3:0] SRC_CONST = 4'h9;
  localparam logic [3:0] DST_ACC   = 4'h8;

  typedef enum logic [3:0] {
    ALU_ACC, ALU_S, ALU_ADD, ALU_SUB, ALU_RSUB, ALU_AND, ALU_OR,
    ALU_NOTS, ALU_INC, ALU_DECS, ALU_ZERO, ALU_ONE
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_SHL, SH_SHR, SH_ROL, SH_ROR, SH_ASL, SH_ASR, SH_RSV, SH_PASS
  } sh_op_e;

  typedef struct packed {
    logic [3:0] src;
    alu_op_e    alu;
    sh_op_e     sh;
    logic [3:0] dst;
  } cmd_t;
endpackage

// File: rtl/ucdp_srcsel.sv
module ucdp_srcsel
  import ucdp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic [3:0]                 sel,
  input  logic [NREG-1:0][DW-1:0]    rf,
  input  logic [DW-1:0]              din,
  input  logic [AW-1:0]              cst,
  output logic [DW-1:0]              sbus
);
  always_comb begin
    if (!sel[3])            sbus = rf[sel[RIDX-1:0]];
    else if (sel == SRC_DIN)   sbus = din;
    else if (sel == SRC_CONST) sbus = {{(DW-AW){1'b0}}, cst};
    else                    sbus = '0;
  end
endmodule

// File: rtl/ucdp_alu.sv
module ucdp_alu
  import ucdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  s,
  output logic [DW-1:0]  y
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    unique case (op)
      ALU_ACC:  y = acc;
      ALU_S:    y = s;
      ALU_ADD:  y = acc + s;
      ALU_SUB:  y = acc - s;
      ALU_RSUB: y = s - acc;
      ALU_AND:  y = acc & s;
      ALU_OR:   y = acc | s;
      ALU_NOTS: y = ~s;
      ALU_INC:  y = acc + ONE;
      ALU_DECS: y = s - ONE;
      ALU_ONE:  y = ONE;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/ucdp_shifter.sv
module ucdp_shifter
  import ucdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  sh_op_e         op,
  input  logic [DW-1:0]  a,
  output logic [DW-1:0]  y,
  output logic           cf
);
  always_comb begin
    case (op)
      SH_SHL, SH_ASL: begin y = {a[DW-2:0], 1'b0};    cf = a[DW-1]; end
      SH_SHR:         begin y = {1'b0, a[DW-1:1]};    cf = a[0];    end
      SH_ASR:         begin y = {a[DW-1], a[DW-1:1]}; cf = a[0];    end
      SH_ROL:         begin y = {a[DW-2:0], a[DW-1]}; cf = a[DW-1]; end
      SH_ROR:         begin y = {a[0], a[DW-1:1]};    cf = a[0];    end
      default:        begin y = a;                    cf = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/ucdp_regfile.sv
module ucdp_regfile
  import ucdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [RIDX-1:0]         widx,
  input  logic [DW-1:0]           wdata,
  output logic [NREG-1:0][DW-1:0] rf_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rf_o[i] <= '0;
      else if (we && widx == RIDX'(i))     rf_o[i] <= wdata;
    end
  end

  // R8
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rf_o[$past(widx)] == $past(wdata));
  // R10
  rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rf_o));
endmodule

// File: rtl/ucdp_core.sv
module ucdp_core
  import ucdp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [14:0]    cmd_i,
  input  logic [AW-1:0]  const_i,
  input  logic [DW-1:0]  din_i,
  output logic [DW-1:0]  result_o,
  output logic [DW-1:0]  acc_o,
  output logic           cf_o,
  output logic           zf_o
);
  cmd_t                    cmd;
  logic [NREG-1:0][DW-1:0] rf;
  logic [DW-1:0]           sbus, alu_y, acc_q;
  logic                    rf_we, acc_we;

  assign cmd    = cmd_t'(cmd_i);
  assign rf_we  = !cmd.dst[3];
  assign acc_we = (cmd.dst == DST_ACC);

  ucdp_srcsel #(.DW(DW), .AW(AW)) u_src (
    .sel(cmd.src), .rf(rf), .din(din_i), .cst(const_i), .sbus(sbus));

  ucdp_alu #(.DW(DW)) u_alu (
    .op(cmd.alu), .acc(acc_q), .s(sbus), .y(alu_y));

  ucdp_shifter #(.DW(DW)) u_sh (
    .op(cmd.sh), .a(alu_y), .y(result_o), .cf(cf_o));

  ucdp_regfile #(.DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(cmd.dst[RIDX-1:0]),
    .wdata(result_o), .rf_o(rf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_we) acc_q <= result_o;
  end

  assign acc_o = acc_q;
  assign zf_o  = (result_o == '0);

  // R1
  const_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.src == SRC_CONST) |-> (sbus[DW-1:AW] == '0));
  // R9
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> acc_o == $past(result_o));
  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(acc_o));
  // R7
  pass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.sh == SH_PASS || cmd.sh == SH_RSV) |-> (result_o == alu_y && !cf_o));
  // R5
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.sh == SH_ROL) |-> (cf_o == alu_y[DW-1]));
endmodule

// File: tb/ucdp_core_test.sv
module ucdp_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cmd;
  logic [11:0] cst;
  logic [15:0] din;
  logic [15:0] res, acc;
  logic        cf, zf;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ucdp_core uut (.clk(clk), .rst_n(rst_n), .cmd_i(cmd), .const_i(cst),
    .din_i(din), .result_o(res), .acc_o(acc), .cf_o(cf), .zf_o(zf));

  // fields: src alu sh dst | const | din | exp result | cf | zf | req number
  localparam int NV = 37;
  localparam logic [64:0] VEC [NV] = '{
    {4'h8,4'h1,3'h7,4'h0, 12'h000, 16'h8001, 16'h8001, 1'b0,1'b0, 4'd1},  // R1 din -> R0
    {4'h9,4'h1,3'h7,4'h8, 12'h0F0, 16'h0000, 16'h00F0, 1'b0,1'b0, 4'd9},  // R9 const -> ACC
    {4'h0,4'h2,3'h7,4'h1, 12'h000, 16'h0000, 16'h80F1, 1'b0,1'b0, 4'd2},  // R2 add -> R1
    {4'h1,4'h1,3'h0,4'h2, 12'h000, 16'h0000, 16'h01E2, 1'b1,1'b0, 4'd4},  // R4 shl
    {4'h1,4'h1,3'h1,4'h3, 12'h000, 16'h0000, 16'h4078, 1'b1,1'b0, 4'd4},  // R4 shr
    {4'h1,4'h1,3'h2,4'h4, 12'h000, 16'h0000, 16'h01E3, 1'b1,1'b0, 4'd4},  // R4 rol
    {4'h0,4'h1,3'h3,4'h5, 12'h000, 16'h0000, 16'hC000, 1'b1,1'b0, 4'd4},  // R4 ror
    {4'h1,4'h1,3'h5,4'h6, 12'h000, 16'h0000, 16'hC078, 1'b1,1'b0, 4'd4},  // R4 asr
    {4'h3,4'h1,3'h4,4'h7, 12'h000, 16'h0000, 16'h80F0, 1'b0,1'b0, 4'd5},  // R5 asl carry 0
    {4'h0,4'h3,3'h7,4'hF, 12'h000, 16'h0000, 16'h80EF, 1'b0,1'b0, 4'd2},  // R2 acc-s
    {4'h0,4'h4,3'h7,4'hF, 12'h000, 16'h0000, 16'h7F11, 1'b0,1'b0, 4'd2},  // R2 s-acc
    {4'h1,4'h5,3'h7,4'hF, 12'h000, 16'h0000, 16'h00F0, 1'b0,1'b0, 4'd3},  // R3 and
    {4'h1,4'h6,3'h7,4'hF, 12'h000, 16'h0000, 16'h80F1, 1'b0,1'b0, 4'd3},  // R3 or
    {4'h2,4'h7,3'h7,4'hF, 12'h000, 16'h0000, 16'hFE1D, 1'b0,1'b0, 4'd3},  // R3 not
    {4'h0,4'h8,3'h7,4'hF, 12'h000, 16'h0000, 16'h00F1, 1'b0,1'b0, 4'd2},  // R2 acc+1
    {4'h0,4'h9,3'h7,4'hF, 12'h000, 16'h0000, 16'h8000, 1'b0,1'b0, 4'd2},  // R2 s-1
    {4'h0,4'hA,3'h7,4'hF, 12'h000, 16'h0000, 16'h0000, 1'b0,1'b1, 4'd6},  // R6 const 0
    {4'h0,4'hB,3'h7,4'hF, 12'h000, 16'h0000, 16'h0001, 1'b0,1'b0, 4'd3},  // R3 const 1
    {4'h0,4'hC,3'h7,4'hF, 12'h000, 16'h0000, 16'h0000, 1'b0,1'b1, 4'd3},  // R3 unlisted
    {4'h0,4'h0,3'h7,4'hF, 12'h000, 16'h0000, 16'h00F0, 1'b0,1'b0, 4'd10}, // R10 ACC kept
    {4'h4,4'h1,3'h6,4'hF, 12'h000, 16'h0000, 16'h01E3, 1'b0,1'b0, 4'd7},  // R7 code 110
    {4'h9,4'h1,3'h7,4'h9, 12'h123, 16'h0000, 16'h0123, 1'b0,1'b0, 4'd10}, // R10 dst 9
    {4'h0,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h8001, 1'b0,1'b0, 4'd8},  // R8 read R0
    {4'h1,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h80F1, 1'b0,1'b0, 4'd8},
    {4'h2,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h01E2, 1'b0,1'b0, 4'd8},
    {4'h3,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h4078, 1'b0,1'b0, 4'd8},
    {4'h4,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h01E3, 1'b0,1'b0, 4'd8},
    {4'h5,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'hC000, 1'b0,1'b0, 4'd8},
    {4'h6,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'hC078, 1'b0,1'b0, 4'd8},
    {4'h7,4'h1,3'h7,4'hF, 12'h000, 16'h0000, 16'h80F0, 1'b0,1'b0, 4'd8},
    {4'h8,4'h1,3'h0,4'h8, 12'h000, 16'h8000, 16'h0000, 1'b1,1'b1, 4'd6},  // R6 shift to zero
    {4'h0,4'h0,3'h7,4'hF, 12'h000, 16'h0000, 16'h0000, 1'b0,1'b1, 4'd9},  // R9 ACC now 0
    {4'h2,4'h1,3'h7,4'h8, 12'h000, 16'h0000, 16'h01E2, 1'b0,1'b0, 4'd12}, // R12 ACC<-R2
    {4'h0,4'h0,3'h7,4'hF, 12'h000, 16'h0000, 16'h01E2, 1'b0,1'b0, 4'd12},
    {4'h9,4'h1,3'h7,4'hF, 12'hFFF, 16'h0000, 16'h0FFF, 1'b0,1'b0, 4'd1},  // R1 zero ext
    {4'h0,4'h8,3'h3,4'hF, 12'h000, 16'h0000, 16'h80F1, 1'b1,1'b0, 4'd5},  // R5 ror carry
    {4'h6,4'h1,3'h1,4'hF, 12'h000, 16'h0000, 16'h603C, 1'b0,1'b0, 4'd5}   // R5 shr carry 0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    cmd = {4'hF, 4'h0, 3'h7, 4'hF}; cst = '0; din = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 acc in reset", acc, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    cmd = {4'h3, 4'h1, 3'h7, 4'hF}; #1;
    chk("R11 R3 after reset", res, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd = VEC[i][64:50]; cst = VEC[i][49:38]; din = VEC[i][37:22];
      #1;
      chk($sformatf("R%0d vec %0d result", VEC[i][3:0], i), res, VEC[i][21:6]);
      chk($sformatf("R%0d vec %0d cf", VEC[i][3:0], i), {15'd0, cf}, {15'd0, VEC[i][5]});
      chk($sformatf("R%0d vec %0d zf", VEC[i][3:0], i), {15'd0, zf}, {15'd0, VEC[i][4]});
    end
    // R9: ACC loaded by the ACC<-R2 vector and still held
    @(negedge clk); #1;
    chk("R9 acc port", acc, 16'h01E2);
    // R11: reset in mid-run clears ACC and registers
    rst_n = 1'b0; #1;
    chk("R11 acc cleared", acc, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    cmd = {4'h1, 4'h1, 3'h7, 4'hF}; #1;
    chk("R11 R1 cleared", res, 16'h0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule